// File: doc/BRIEF.md
# External Agent Single-Write Sequencer

This block sits on the external-agent side of a shared processor system bus and turns one local write request into a single bus write. Local logic hands it an address and a data word through a valid/ready handshake. The block then asks for the bus with an active-low request line and waits until the processor gives up mastership. After that it drives two back-to-back bus cycles, each qualified by a one-cycle active-low valid strobe. The first cycle carries the write command and the address. The second carries a data identifier, marked as the final data cycle, together with the data word.

The request line stays low from the cycle after acceptance until the data cycle is over, so mastership is held for the whole transfer. The command and address/data drivers are enabled only during the two strobed cycles and float at all other times. Only one write can be in flight, because the local side is not ready again until the sequence ends.

Top module: `ewr_seq`

## Requirements
- R1: After reset, `ereq_n` and `evalid_n` are high, `cmd_oe` and `ad_oe` are low, and `loc_ready` is high.
- R2: A request is accepted on a rising edge where `loc_valid` and `loc_ready` are both high. In the following cycle `loc_ready` is low and `ereq_n` is low.
- R3: While `pmaster_n` is low, no bus cycle starts. The address cycle comes in the cycle after the first edge at which `pmaster_n` is sampled high with `ereq_n` low.
- R4: In the address cycle `evalid_n` is low for that one cycle, `cmd_o` equals 9'h080 (bit 8 = 0 marks a command, bits 7:5 = 3'b100 mark a write), and `ad_o` carries the accepted address zero-extended to the bus width.
- R5: The data cycle immediately follows the address cycle. In it `evalid_n` is low, `cmd_o` equals 9'h180 (bit 8 = 1 marks a data identifier, bit 7 = 1 marks the last data cycle), and `ad_o` carries the accepted data.
- R6: `ereq_n` stays low through both bus cycles and goes high in the cycle right after the data cycle, when `loc_ready` is high again.
- R7: Whenever `evalid_n` is high, `cmd_oe` and `ad_oe` are low, so the bus floats.
- R8: `loc_valid` pulses while `loc_ready` is low are ignored. They produce no bus cycle, then or later.
- R9: Once the address cycle has started, `pmaster_n` has no effect, and the data cycle still follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_valid | input | 1 | Local write request valid |
| loc_ready | output | 1 | Sequencer can accept a request |
| loc_addr | input | AW | Local write address |
| loc_data | input | DW | Local write data |
| pmaster_n | input | 1 | Processor master indication, active low |
| ereq_n | output | 1 | External bus request, active low |
| evalid_n | output | 1 | External valid strobe, active low |
| cmd_o | output | 9 | Command / data identifier |
| cmd_oe | output | 1 | Command bus drive enable |
| ad_o | output | BUS_W | Address / data bus value |
| ad_oe | output | 1 | Address / data bus drive enable |

## Verification
Two events can fall on the same edge. The first is the release of the bus request after a data cycle. The second is the acceptance of the next local write, which is possible because ready returns in that very cycle. The bench provokes this by issuing two writes back to back. It then judges that the request line is high for exactly one cycle between the two transfers, and that the second pair of strobed cycles carries the second address and data. A second overlap is a drop of the processor master indication during the address cycle. The bench injects this drop and checks that the data cycle still arrives on the next cycle.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_ADDR = 2'd2,
      ST_DATA = 2'd3
   } ewr_state_e;

   localparam int CMD_W     = 9;
   localparam int ID_BIT    = 8;   // 1: data identifier, 0: command
   localparam int LAST_BIT  = 7;   // last data cycle flag in identifier
   localparam logic [CMD_W-1:0] CMD_WRITE = 9'h080;
   localparam logic [CMD_W-1:0] DID_LAST  = 9'h180;
endpackage

// File: rtl/ewr_hold_regs.sv
module ewr_hold_regs #(
   parameter int AW    = 32,
   parameter int DW    = 64,
   parameter int BUS_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    data_i,
   output logic [BUS_W-1:0] addr_bus_o,
   output logic [BUS_W-1:0] data_bus_o
);
   localparam int APAD = BUS_W - AW;
   localparam int DPAD = BUS_W - DW;

   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (load) begin
         addr_q <= addr_i;
         data_q <= data_i;
      end
   end

   generate
      if (APAD > 0) begin : g_apad
         assign addr_bus_o = {{APAD{1'b0}}, addr_q};
      end else begin : g_afull
         assign addr_bus_o = addr_q;
      end
      if (DPAD > 0) begin : g_dpad
         assign data_bus_o = {{DPAD{1'b0}}, data_q};
      end else begin : g_dfull
         assign data_bus_o = data_q;
      end
   endgenerate
endmodule

// File: rtl/ewr_seq_fsm.sv
module ewr_seq_fsm
   import ewr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       pmaster_n,
   output ewr_state_e state_o,
   output logic       accept_o
);
   ewr_state_e st_q, st_d;

   assign accept_o = (st_q == ST_IDLE) && req_valid;
   assign state_o  = st_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (req_valid) st_d = ST_REQ;
         ST_REQ:  if (pmaster_n) st_d = ST_ADDR;
         ST_ADDR: st_d = ST_DATA;
         ST_DATA: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/ewr_bus_drive.sv
module ewr_bus_drive
   import ewr_pkg::*;
#(
   parameter int BUS_W = 64
) (
   input  ewr_state_e        state_i,
   input  logic [BUS_W-1:0]  addr_bus_i,
   input  logic [BUS_W-1:0]  data_bus_i,
   output logic              ready_o,
   output logic              ereq_n_o,
   output logic              evalid_n_o,
   output logic [CMD_W-1:0]  cmd_o,
   output logic              cmd_oe_o,
   output logic [BUS_W-1:0]  ad_o,
   output logic              ad_oe_o
);
   logic phase_a, phase_d;

   assign phase_a    = (state_i == ST_ADDR);
   assign phase_d    = (state_i == ST_DATA);
   assign ready_o    = (state_i == ST_IDLE);
   assign ereq_n_o   = (state_i == ST_IDLE);
   assign evalid_n_o = !(phase_a || phase_d);
   assign cmd_oe_o   = phase_a || phase_d;
   assign ad_oe_o    = phase_a || phase_d;

   always_comb begin
      cmd_o = '0;
      ad_o  = '0;
      if (phase_a) begin
         cmd_o = CMD_WRITE;
         ad_o  = addr_bus_i;
      end else if (phase_d) begin
         cmd_o = DID_LAST;
         ad_o  = data_bus_i;
      end
   end
endmodule

// File: rtl/ewr_seq.sv
module ewr_seq
   import ewr_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 64,
   parameter int BUS_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loc_valid,
   output logic             loc_ready,
   input  logic [AW-1:0]    loc_addr,
   input  logic [DW-1:0]    loc_data,
   input  logic             pmaster_n,
   output logic             ereq_n,
   output logic             evalid_n,
   output logic [8:0]       cmd_o,
   output logic             cmd_oe,
   output logic [BUS_W-1:0] ad_o,
   output logic             ad_oe
);
   generate
      if (AW > BUS_W || AW < 1) begin : g_bad_aw
         $error("ewr_seq: AW must be 1..BUS_W");
      end
      if (DW > BUS_W || DW < 1) begin : g_bad_dw
         $error("ewr_seq: DW must be 1..BUS_W");
      end
   endgenerate

   ewr_state_e       state;
   logic             accept;
   logic [BUS_W-1:0] addr_bus, data_bus;

   ewr_seq_fsm i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (loc_valid),
      .pmaster_n (pmaster_n),
      .state_o   (state),
      .accept_o  (accept)
   );

   ewr_hold_regs #(.AW(AW), .DW(DW), .BUS_W(BUS_W)) i_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .addr_i     (loc_addr),
      .data_i     (loc_data),
      .addr_bus_o (addr_bus),
      .data_bus_o (data_bus)
   );

   ewr_bus_drive #(.BUS_W(BUS_W)) i_drv (
      .state_i    (state),
      .addr_bus_i (addr_bus),
      .data_bus_i (data_bus),
      .ready_o    (loc_ready),
      .ereq_n_o   (ereq_n),
      .evalid_n_o (evalid_n),
      .cmd_o      (cmd_o),
      .cmd_oe_o   (cmd_oe),
      .ad_o       (ad_o),
      .ad_oe_o    (ad_oe)
   );
endmodule

// File: rtl/ewr_seq_chk.sv
module ewr_seq_chk
   import ewr_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       loc_valid,
   input logic       loc_ready,
   input logic       pmaster_n,
   input logic       ereq_n,
   input logic       evalid_n,
   input logic [8:0] cmd_o,
   input logic       cmd_oe,
   input logic       ad_oe
);
   logic a_cyc, d_cyc;
   assign a_cyc = !evalid_n && !cmd_o[ID_BIT];
   assign d_cyc = !evalid_n &&  cmd_o[ID_BIT];

   p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_valid && loc_ready) |=> (!loc_ready && !ereq_n));

   p_addr_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      a_cyc |-> ($past(pmaster_n) && !$past(ereq_n) && $past(evalid_n)));

   p_write_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      a_cyc |-> (cmd_o == CMD_WRITE));

   p_data_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      a_cyc |=> (d_cyc && cmd_o[LAST_BIT]));

   p_strobe_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !evalid_n |-> !ereq_n);

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      d_cyc |=> (ereq_n && evalid_n && loc_ready));

   p_float_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evalid_n |-> (!cmd_oe && !ad_oe));
endmodule

bind ewr_seq ewr_seq_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .loc_valid (loc_valid),
   .loc_ready (loc_ready),
   .pmaster_n (pmaster_n),
   .ereq_n    (ereq_n),
   .evalid_n  (evalid_n),
   .cmd_o     (cmd_o),
   .cmd_oe    (cmd_oe),
   .ad_oe     (ad_oe)
);

// File: tb/test_ewr_seq.sv
`timescale 1ns/1ps
module test_ewr_seq;
   localparam int AW = 32, DW = 64, BW = 64;

   logic          clk = 0, rst_n = 0;
   logic          loc_valid = 0;
   logic [AW-1:0] loc_addr = '0;
   logic [DW-1:0] loc_data = '0;
   logic          pmaster_n = 0;
   logic          loc_ready, ereq_n, evalid_n, cmd_oe, ad_oe;
   logic [8:0]    cmd_o;
   logic [BW-1:0] ad_o;

   ewr_seq #(.AW(AW), .DW(DW), .BUS_W(BW)) i_ewr_seq (
      .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_ready(loc_ready),
      .loc_addr(loc_addr), .loc_data(loc_data), .pmaster_n(pmaster_n),
      .ereq_n(ereq_n), .evalid_n(evalid_n), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
      .ad_o(ad_o), .ad_oe(ad_oe));

   always #10 clk = ~clk;

   int checks = 0, bad = 0, cyc = 0;
   int gdelay = 1, gcnt = 0, acc_cyc = -1, addr_cyc = 0;
   bit drop_in_addr = 0, after_data = 0;
   logic [72:0] exp_q[$];   // {cmd, bus value}

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // monitor, scoreboard and processor grant model
   always @(negedge clk) begin
      if (rst_n) begin
         if (evalid_n) begin
            chk(!cmd_oe && !ad_oe, "R7 float", {cmd_oe, ad_oe}, 0);
            if (after_data) begin
               chk(ereq_n, "R6 release", ereq_n, 1);
               chk(loc_ready, "R6 ready back", loc_ready, 1);
            end
            after_data = 0;
         end else if (exp_q.size() == 0) begin
            chk(0, "R8 unexpected strobe", cmd_o, 0);
         end else begin
            logic [72:0] e;
            e = exp_q.pop_front();
            chk(cmd_o == e[72:64], cmd_o[8] ? "R5 identifier" : "R4 command", cmd_o, e[72:64]);
            chk(ad_o == e[63:0], cmd_o[8] ? "R5 data" : "R4 address", ad_o, e[63:0]);
            if (e[72]) begin
               chk(cyc == addr_cyc + 1, "R5 consecutive", cyc, addr_cyc + 1);
               after_data = 1;
            end else begin
               addr_cyc = cyc;
               if (acc_cyc >= 0) chk(cyc - acc_cyc == gdelay, "R3 grant latency", cyc - acc_cyc, gdelay);
               acc_cyc = -1;
            end
         end
         if (ereq_n) begin
            gcnt = 0;
            pmaster_n = 0;
         end else begin
            gcnt++;
            pmaster_n = (gcnt >= gdelay);
            if (drop_in_addr && !evalid_n && !cmd_o[8]) pmaster_n = 0;  // R9
         end
      end
   end

   task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      while (!loc_ready) @(negedge clk);
      loc_valid = 1; loc_addr = a; loc_data = d;
      exp_q.push_back({9'h080, {{(BW-AW){1'b0}}, a}});
      exp_q.push_back({9'h180, d});
      @(posedge clk); #1;
      acc_cyc = cyc;
      loc_valid = 0;
      @(negedge clk);
      chk(!loc_ready && !ereq_n, "R2 busy and request", {loc_ready, ereq_n}, 0);
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (exp_q.size() != 0 || !ereq_n) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #100000000;
      bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ereq_n && evalid_n && !cmd_oe && !ad_oe && loc_ready, "R1 reset state",
          {ereq_n, evalid_n, cmd_oe, ad_oe, loc_ready}, 5'b11001);
      rst_n = 1;
      repeat (2) @(negedge clk);

      gdelay = 1; send(32'h1000_0040, 64'hDEAD_BEEF_0123_4567); wait_done();
      gdelay = 3; send(32'hFFFF_FFFC, 64'hFFFF_FFFF_FFFF_FFFF); wait_done();

      // R9: master indication dropped during the address cycle
      gdelay = 4; drop_in_addr = 1;
      send(32'h0000_0000, 64'h0); wait_done();
      drop_in_addr = 0;

      // R8: stray valid pulses while busy
      gdelay = 6;
      send(32'h2222_2220, 64'h5555_AAAA_5555_AAAA);
      loc_valid = 1; loc_addr = 32'h9999_9990; loc_data = 64'h1;
      @(negedge clk);
      chk(!loc_ready, "R8 busy", loc_ready, 0);
      @(negedge clk);
      loc_valid = 0;
      wait_done();
      repeat (8) @(negedge clk);
      chk(exp_q.size() == 0 && ereq_n, "R8 no extra transfer", exp_q.size(), 0);

      // back to back: release and new accept on the same edge
      gdelay = 1;
      send(32'h0000_1110, 64'h0102_0304_0506_0708);
      send(32'h0000_2220, 64'h1112_1314_1516_1718);
      wait_done();

      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule